// File: doc/BRIEF.md
# AC-link Codec Register Access Engine

This block sits on the controller side of an AC-link. It gives a host a small register window for reading and writing the control registers of an attached audio codec through the two command slots of each frame. The host writes a data word into a slot-2 holding register, then writes an address word into a slot-1 holding register. The slot-1 write commits the access, and that same write claims any slot-2 word that is waiting. An abstract frame interface pulses once per audio frame. On that pulse the engine presents the committed words with their tag-valid bits and takes in whatever slot words the codec returned.

Returned slot words are latched into two receive registers. Each has a valid flag that a host read of the register clears. For a read access, the address echoed in returned slot 1 is compared with the requested address. On a mismatch the engine raises a flag and refuses the slot-2 data of that frame. A main control register holds a global enable, per-slot transmit and receive enables, and the number of the codec being addressed.

Top module: `codec_cmd_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, the control register, every status flag, both receive registers and the outputs `tx_tag`, `tx_slot1`, `tx_slot2` and `tx_codec` become zero.
- R2: Register offsets are: 0 control, 1 slot-1 transmit, 2 slot-2 transmit, 3 slot-1 receive, 4 slot-2 receive, 5 status. A host write to offset 1 sets status bit 0 (slot-1 busy). On the next `frame_strobe`, the written word appears on `tx_slot1` with `tx_tag` bit 0 set, and status bit 0 clears.
- R3: A word written to offset 2 sets status bit 1 (slot-2 busy). It is not sent until a later write to offset 1 arms it. It then goes out on `tx_slot2` with `tx_tag` bit 1 in the same frame as the slot-1 word. A second write to offset 2 before that frame disarms it again.
- R4: Control bit 1 enables slot-1 transmit and control bit 2 enables slot-2 transmit. While a slot's enable is clear, its word is not sent and its busy bit stays set. The word is sent at the first strobe after the enable is set.
- R5: A slot-1 word with bit 19 set is a read request for the codec register address in bits [18:12]. The word goes out unchanged on `tx_slot1`.
- R6: Control bit 3 enables slot-1 receive and control bit 4 enables slot-2 receive. At a `frame_strobe`, `in_slot1` is latched when `in_tag` bit 0 is set and slot-1 receive is enabled, and this sets status bit 2. `in_slot2` is latched when `in_tag` bit 1 is set and slot-2 receive is enabled, and this sets status bit 3. Without the tag or the enable, nothing is latched.
- R7: A host read of offset 3 clears status bit 2, and a host read of offset 4 clears status bit 3. The receive registers return the latched 20-bit words unchanged.
- R8: While a read request is pending, a latched slot-1 word whose bits [18:12] differ from the requested address sets status bit 4 (echo mismatch). The slot-2 word of that frame is then not latched. Bit 4 stays set until the next slot-1 write.
- R9: Control bits [9:8] select the codec (0 to 3). `tx_codec` takes that value at every `frame_strobe`.
- R10: Control bit 0 is the global enable. While it is clear, all busy, armed, valid and mismatch flags, the receive registers and `tx_tag` are held at zero, and writes to offsets 1 and 2 are ignored.
- R11: Status reads return busy1 in bit 0, busy2 in bit 1, valid1 in bit 2, valid2 in bit 3 and mismatch in bit 4. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (clears receive-valid on offsets 3, 4) |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 20 | Host write data |
| host_rdata | output | 20 | Host read data (combinational on host_addr) |
| frame_strobe | input | 1 | One pulse per audio frame |
| in_tag | input | 2 | Returned slot-valid tags: bit 0 slot 1, bit 1 slot 2 |
| in_slot1 | input | 20 | Returned slot-1 word (address echo) |
| in_slot2 | input | 20 | Returned slot-2 word (data) |
| tx_tag | output | 2 | Outgoing slot-valid tags for the current frame |
| tx_slot1 | output | 20 | Outgoing slot-1 word |
| tx_slot2 | output | 20 | Outgoing slot-2 word |
| tx_codec | output | 2 | Codec number for the current frame |

## Verification
A busy flag that fails to clear shows in the next status read after a frame. A stuck armed flag shows on `tx_tag` at the very next strobe, as a slot-2 word sent alone or one missing from its pair. A receive-valid flag that is wrong shows one cycle after the strobe or after the host read that should change it. A faulty echo comparison shows in the status bit 4 read after the response frame, and in the slot-2 receive register still holding its previous word.

// File: rtl/cae_pkg.sv
// Package: shared constants and the control-register type for the codec
// command engine. Bit positions here are the host-visible layout.
package cae_pkg;
    localparam int CODEC_W  = 2;

    // register offsets
    localparam int OFF_CTRL = 0;
    localparam int OFF_TX1  = 1;
    localparam int OFF_TX2  = 2;
    localparam int OFF_RX1  = 3;
    localparam int OFF_RX2  = 4;
    localparam int OFF_STAT = 5;

    // control-register bit positions
    localparam int CB_EN    = 0;
    localparam int CB_TX1   = 1;
    localparam int CB_TX2   = 2;
    localparam int CB_RX1   = 3;
    localparam int CB_RX2   = 4;
    localparam int CB_CODEC = 8;

    // status-register bit positions
    localparam int ST_BUSY1 = 0;
    localparam int ST_BUSY2 = 1;
    localparam int ST_VAL1  = 2;
    localparam int ST_VAL2  = 3;
    localparam int ST_MISM  = 4;
    localparam int ST_W     = 5;

    typedef struct packed {
        logic [CODEC_W-1:0] codec;
        logic               rx2_en;
        logic               rx1_en;
        logic               tx2_en;
        logic               tx1_en;
        logic               glb_en;
    } ctrl_t;
endpackage

// File: rtl/cae_regs.sv
// Module: cae_regs
// Host register window: holds the control register, turns host accesses
// into one-cycle command pulses and muxes the read data.
// Assumes: single-cycle host accesses; host_rdata is valid in the cycle
// host_addr is presented. Slot writes are dropped while globally disabled.
module cae_regs
    import cae_pkg::*;
#(
    parameter int SLOT_W = 20,
    parameter int REG_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [REG_AW-1:0] host_addr,
    input  logic [SLOT_W-1:0] host_wdata,
    output logic [SLOT_W-1:0] host_rdata,
    output ctrl_t             ctrl,
    output logic              wr_tx1,
    output logic              wr_tx2,
    output logic              rd_rx1,
    output logic              rd_rx2,
    input  logic [ST_W-1:0]   stat,
    input  logic [SLOT_W-1:0] rx1_word,
    input  logic [SLOT_W-1:0] rx2_word
);
    localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(OFF_CTRL);
    localparam logic [REG_AW-1:0] A_TX1  = REG_AW'(OFF_TX1);
    localparam logic [REG_AW-1:0] A_TX2  = REG_AW'(OFF_TX2);
    localparam logic [REG_AW-1:0] A_RX1  = REG_AW'(OFF_RX1);
    localparam logic [REG_AW-1:0] A_RX2  = REG_AW'(OFF_RX2);
    localparam logic [REG_AW-1:0] A_STAT = REG_AW'(OFF_STAT);

    // Purpose: capture the control register on a host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (host_wr && host_addr == A_CTRL) begin
            ctrl.glb_en <= host_wdata[CB_EN];
            ctrl.tx1_en <= host_wdata[CB_TX1];
            ctrl.tx2_en <= host_wdata[CB_TX2];
            ctrl.rx1_en <= host_wdata[CB_RX1];
            ctrl.rx2_en <= host_wdata[CB_RX2];
            ctrl.codec  <= host_wdata[CB_CODEC +: CODEC_W];
        end
    end

    // Purpose: decode host accesses into command pulses.
    always_comb begin
        wr_tx1 = host_wr && host_addr == A_TX1 && ctrl.glb_en;
        wr_tx2 = host_wr && host_addr == A_TX2 && ctrl.glb_en;
        rd_rx1 = host_rd && host_addr == A_RX1;
        rd_rx2 = host_rd && host_addr == A_RX2;
    end

    // Purpose: select the word returned to the host.
    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            A_CTRL: begin
                host_rdata[CB_EN]                = ctrl.glb_en;
                host_rdata[CB_TX1]               = ctrl.tx1_en;
                host_rdata[CB_TX2]               = ctrl.tx2_en;
                host_rdata[CB_RX1]               = ctrl.rx1_en;
                host_rdata[CB_RX2]               = ctrl.rx2_en;
                host_rdata[CB_CODEC +: CODEC_W]  = ctrl.codec;
            end
            A_RX1:   host_rdata = rx1_word;
            A_RX2:   host_rdata = rx2_word;
            A_STAT:  host_rdata[ST_W-1:0] = stat;
            default: host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cae_tx.sv
// Module: cae_tx
// Transmit side: holds the two command-slot words, tracks per-slot busy
// and the slot-2 armed state, and presents sent words at each frame.
// Assumes: frame_strobe is a single-cycle pulse; a host write in the same
// cycle as a strobe wins over the strobe's clearing of busy.
module cae_tx
    import cae_pkg::*;
#(
    parameter int SLOT_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               glb_en,
    input  logic               tx1_en,
    input  logic               tx2_en,
    input  logic [CODEC_W-1:0] codec,
    input  logic               wr_tx1,
    input  logic               wr_tx2,
    input  logic [SLOT_W-1:0]  wdata,
    input  logic               frame_strobe,
    output logic               busy1,
    output logic               busy2,
    output logic               armed2,
    output logic [1:0]         tx_tag,
    output logic [SLOT_W-1:0]  tx_slot1,
    output logic [SLOT_W-1:0]  tx_slot2,
    output logic [CODEC_W-1:0] tx_codec
);
    logic [SLOT_W-1:0] hold1;
    logic [SLOT_W-1:0] hold2;
    logic              send1;
    logic              send2;

    // Purpose: decide which committed slots leave in this frame.
    always_comb begin
        send1 = frame_strobe && busy1 && tx1_en;
        send2 = frame_strobe && armed2 && tx2_en;
    end

    // Purpose: slot-1 holding word and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !glb_en) begin
            hold1 <= '0;
            busy1 <= 1'b0;
        end else begin
            if (wr_tx1) hold1 <= wdata;
            if (wr_tx1)      busy1 <= 1'b1;
            else if (send1)  busy1 <= 1'b0;
        end
    end

    // Purpose: slot-2 holding word, busy flag and arming by a slot-1 write.
    always_ff @(posedge clk) begin
        if (!rst_n || !glb_en) begin
            hold2  <= '0;
            busy2  <= 1'b0;
            armed2 <= 1'b0;
        end else begin
            if (wr_tx2) hold2 <= wdata;
            if (wr_tx2)      busy2 <= 1'b1;
            else if (send2)  busy2 <= 1'b0;
            if (wr_tx2 || send2) armed2 <= 1'b0;
            else if (wr_tx1)     armed2 <= busy2;
        end
    end

    // Purpose: present the frame's outgoing words, tags and codec number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_tag   <= '0;
            tx_slot1 <= '0;
            tx_slot2 <= '0;
            tx_codec <= '0;
        end else if (!glb_en) begin
            tx_tag   <= '0;
        end else if (frame_strobe) begin
            tx_tag   <= {send2, send1};
            tx_codec <= codec;
            if (send1) tx_slot1 <= hold1;
            if (send2) tx_slot2 <= hold2;
        end
    end
endmodule

// File: rtl/cae_rx.sv
// Module: cae_rx
// Receive side: latches returned slot words per tag and enable, keeps the
// valid flags, and checks the address echo of a pending read.
// Assumes: at most one read request outstanding; a new slot-1 write
// replaces the pending request and clears the mismatch flag.
module cae_rx
    import cae_pkg::*;
#(
    parameter int SLOT_W   = 20,
    parameter int ADDR_LSB = 12,
    parameter int ADDR_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glb_en,
    input  logic              rx1_en,
    input  logic              rx2_en,
    input  logic              frame_strobe,
    input  logic [1:0]        in_tag,
    input  logic [SLOT_W-1:0] in_slot1,
    input  logic [SLOT_W-1:0] in_slot2,
    input  logic              wr_tx1,
    input  logic              req_rd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              rd_rx1,
    input  logic              rd_rx2,
    output logic [SLOT_W-1:0] rx1_word,
    output logic [SLOT_W-1:0] rx2_word,
    output logic              valid1,
    output logic              valid2,
    output logic              mismatch
);
    logic              rd_pend;
    logic [ADDR_W-1:0] pend_addr;
    logic              echo_bad;
    logic [1:0]        cap;
    logic [1:0]        rd_clr;
    logic [1:0]        vld_q;
    logic [SLOT_W-1:0] word_in [2];
    logic [SLOT_W-1:0] word_q  [2];

    // Purpose: decide which returned slots are latched this cycle.
    always_comb begin
        cap[0]   = frame_strobe && in_tag[0] && rx1_en;
        echo_bad = cap[0] && rd_pend && in_slot1[ADDR_LSB +: ADDR_W] != pend_addr;
        cap[1]   = frame_strobe && in_tag[1] && rx2_en && !echo_bad;
        rd_clr   = {rd_rx2, rd_rx1};
        word_in[0] = in_slot1;
        word_in[1] = in_slot2;
    end

    // Purpose: one receive register and valid flag per slot.
    for (genvar s = 0; s < 2; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || !glb_en) begin
                word_q[s] <= '0;
                vld_q[s]  <= 1'b0;
            end else begin
                if (cap[s]) word_q[s] <= word_in[s];
                if (cap[s])         vld_q[s] <= 1'b1;
                else if (rd_clr[s]) vld_q[s] <= 1'b0;
            end
        end
    end

    // Purpose: track the pending read request and the echo-mismatch flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !glb_en) begin
            rd_pend   <= 1'b0;
            pend_addr <= '0;
            mismatch  <= 1'b0;
        end else if (wr_tx1) begin
            rd_pend   <= req_rd;
            pend_addr <= req_addr;
            mismatch  <= 1'b0;
        end else if (cap[0]) begin
            rd_pend   <= 1'b0;
            if (echo_bad) mismatch <= 1'b1;
        end
    end

    assign rx1_word = word_q[0];
    assign rx2_word = word_q[1];
    assign valid1   = vld_q[0];
    assign valid2   = vld_q[1];
endmodule

// File: rtl/codec_cmd_engine.sv
// Module: codec_cmd_engine
// Top of the codec command engine: host register window, transmit side
// for the two command slots and receive side with echo checking.
// Assumes: synchronous active-low reset; one frame_strobe per frame.
module codec_cmd_engine
    import cae_pkg::*;
#(
    parameter int SLOT_W   = 20,
    parameter int REG_AW   = 3,
    parameter int ADDR_LSB = 12,
    parameter int ADDR_W   = 7,
    parameter int RD_BIT   = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [REG_AW-1:0]  host_addr,
    input  logic [SLOT_W-1:0]  host_wdata,
    output logic [SLOT_W-1:0]  host_rdata,
    input  logic               frame_strobe,
    input  logic [1:0]         in_tag,
    input  logic [SLOT_W-1:0]  in_slot1,
    input  logic [SLOT_W-1:0]  in_slot2,
    output logic [1:0]         tx_tag,
    output logic [SLOT_W-1:0]  tx_slot1,
    output logic [SLOT_W-1:0]  tx_slot2,
    output logic [CODEC_W-1:0] tx_codec
);
    ctrl_t             ctrl;
    logic              glb_en;
    logic              tx1_en;
    logic              wr_tx1;
    logic              wr_tx2;
    logic              rd_rx1;
    logic              rd_rx2;
    logic              busy1;
    logic              busy2;
    logic              armed2;
    logic              valid1;
    logic              valid2;
    logic              mismatch;
    logic [SLOT_W-1:0] rx1_word;
    logic [SLOT_W-1:0] rx2_word;
    logic [ST_W-1:0]   stat;

    assign glb_en = ctrl.glb_en;
    assign tx1_en = ctrl.tx1_en;

    // Purpose: assemble the status word.
    always_comb begin
        stat           = '0;
        stat[ST_BUSY1] = busy1;
        stat[ST_BUSY2] = busy2;
        stat[ST_VAL1]  = valid1;
        stat[ST_VAL2]  = valid2;
        stat[ST_MISM]  = mismatch;
    end

    cae_regs #(.SLOT_W(SLOT_W), .REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ctrl(ctrl), .wr_tx1(wr_tx1), .wr_tx2(wr_tx2),
        .rd_rx1(rd_rx1), .rd_rx2(rd_rx2),
        .stat(stat), .rx1_word(rx1_word), .rx2_word(rx2_word)
    );

    cae_tx #(.SLOT_W(SLOT_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .glb_en(glb_en), .tx1_en(tx1_en), .tx2_en(ctrl.tx2_en),
        .codec(ctrl.codec),
        .wr_tx1(wr_tx1), .wr_tx2(wr_tx2), .wdata(host_wdata),
        .frame_strobe(frame_strobe),
        .busy1(busy1), .busy2(busy2), .armed2(armed2),
        .tx_tag(tx_tag), .tx_slot1(tx_slot1), .tx_slot2(tx_slot2),
        .tx_codec(tx_codec)
    );

    cae_rx #(.SLOT_W(SLOT_W), .ADDR_LSB(ADDR_LSB), .ADDR_W(ADDR_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .glb_en(glb_en), .rx1_en(ctrl.rx1_en), .rx2_en(ctrl.rx2_en),
        .frame_strobe(frame_strobe), .in_tag(in_tag),
        .in_slot1(in_slot1), .in_slot2(in_slot2),
        .wr_tx1(wr_tx1), .req_rd(host_wdata[RD_BIT]),
        .req_addr(host_wdata[ADDR_LSB +: ADDR_W]),
        .rd_rx1(rd_rx1), .rd_rx2(rd_rx2),
        .rx1_word(rx1_word), .rx2_word(rx2_word),
        .valid1(valid1), .valid2(valid2), .mismatch(mismatch)
    );
endmodule

// File: rtl/cae_checker.sv
// Module: cae_checker
// Temporal checks on the command engine's slot flags and frame outputs,
// attached to the top through bind.
module cae_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_strobe,
    input logic       glb_en,
    input logic       tx1_en,
    input logic       wr_tx1,
    input logic       busy1,
    input logic       busy2,
    input logic       armed2,
    input logic       valid1,
    input logic       valid2,
    input logic [1:0] in_tag,
    input logic [1:0] tx_tag
);
    p_slot1_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe && !busy1 |=> !tx_tag[0]);

    p_slot1_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        glb_en && frame_strobe && busy1 && tx1_en && !wr_tx1 |=> !busy1);

    p_armed_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed2 |-> busy2);

    p_slot2_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        glb_en && busy2 && !armed2 |=> busy2);

    p_txen_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe && !tx1_en |=> !tx_tag[0]);

    p_rx_needs_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_strobe && in_tag[0]) && !valid1 |=> !valid1);

    p_disable_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> !busy1 && !busy2 && !valid1 && !valid2 && tx_tag == 2'b00);
endmodule

bind codec_cmd_engine cae_checker u_chk (
    .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe),
    .glb_en(glb_en), .tx1_en(tx1_en), .wr_tx1(wr_tx1),
    .busy1(busy1), .busy2(busy2), .armed2(armed2),
    .valid1(valid1), .valid2(valid2), .in_tag(in_tag), .tx_tag(tx_tag)
);

// File: tb/sim_codec_cmd_engine.sv
`timescale 1ns/1ps
// Bench: table-driven host/frame sequence, then directed reset and
// slot-2 disarm corner tests.
module sim_codec_cmd_engine;
    localparam int SW = 20;

    // ops
    localparam logic [2:0] OP_WR  = 3'd0; // host write addr <- data
    localparam logic [2:0] OP_RD  = 3'd1; // host read addr, compare data
    localparam logic [2:0] OP_STB = 3'd2; // frame strobe, in_tag = data[1:0]
    localparam logic [2:0] OP_SET = 3'd3; // addr 0: in_slot1, 1: in_slot2
    localparam logic [2:0] OP_CHK = 3'd4; // addr 0 tag,1 slot1,2 slot2,3 codec
    localparam logic [2:0] OP_NOP = 3'd5;

    function automatic logic [29:0] mk(logic [2:0] op, logic [3:0] rq,
                                       logic [2:0] a, logic [19:0] d);
        return {op, rq, a, d};
    endfunction

    localparam int NV = 62;
    localparam logic [29:0] VEC [NV] = '{
        mk(OP_WR , 9, 0, 20'h0021F),   // R9 codec 2, all enables
        mk(OP_RD , 11, 5, 20'h00000),  // R11 idle status
        mk(OP_RD , 9, 0, 20'h0021F),   // R9 control readback
        mk(OP_WR , 3, 2, 20'h12340),
        mk(OP_RD , 3, 5, 20'h00002),   // R3 busy2 only
        mk(OP_STB, 3, 0, 20'h00000),
        mk(OP_CHK, 3, 0, 20'h00000),   // R3 slot 2 not sent alone
        mk(OP_RD , 3, 5, 20'h00002),   // R3 still busy
        mk(OP_WR , 2, 1, 20'h02000),   // R2 write access to reg 0x02
        mk(OP_RD , 2, 5, 20'h00003),   // R2 busy1 + busy2
        mk(OP_STB, 2, 0, 20'h00000),
        mk(OP_CHK, 3, 0, 20'h00003),   // R3 both in one frame
        mk(OP_CHK, 2, 1, 20'h02000),   // R2 slot1 word
        mk(OP_CHK, 3, 2, 20'h12340),   // R3 slot2 word
        mk(OP_CHK, 9, 3, 20'h00002),   // R9 codec 2
        mk(OP_RD , 2, 5, 20'h00000),   // R2 busy cleared
        mk(OP_WR , 4, 0, 20'h0021D),   // R4 slot1 tx off
        mk(OP_WR , 4, 1, 20'h0C000),
        mk(OP_STB, 4, 0, 20'h00000),
        mk(OP_CHK, 4, 0, 20'h00000),   // R4 nothing sent
        mk(OP_RD , 4, 5, 20'h00001),   // R4 busy held
        mk(OP_WR , 4, 0, 20'h0021F),
        mk(OP_STB, 4, 0, 20'h00000),
        mk(OP_CHK, 4, 0, 20'h00001),   // R4 sent after enable
        mk(OP_WR , 5, 1, 20'hA6000),   // R5 read of reg 0x26
        mk(OP_STB, 5, 0, 20'h00000),
        mk(OP_CHK, 5, 1, 20'hA6000),   // R5 read word on slot 1
        mk(OP_SET, 6, 0, 20'h26000),
        mk(OP_SET, 6, 1, 20'hBEEF0),
        mk(OP_STB, 6, 0, 20'h00003),
        mk(OP_RD , 6, 5, 20'h0000C),   // R6 both valid
        mk(OP_RD , 7, 3, 20'h26000),   // R7 rx1 word
        mk(OP_RD , 7, 5, 20'h00008),   // R7 valid1 cleared
        mk(OP_RD , 7, 4, 20'hBEEF0),   // R7 rx2 word
        mk(OP_RD , 7, 5, 20'h00000),   // R7 valid2 cleared
        mk(OP_STB, 6, 0, 20'h00000),
        mk(OP_RD , 6, 5, 20'h00000),   // R6 no tag, nothing latched
        mk(OP_WR , 6, 0, 20'h00217),   // slot1 rx off
        mk(OP_STB, 6, 0, 20'h00001),
        mk(OP_RD , 6, 5, 20'h00000),   // R6 rx disabled
        mk(OP_WR , 6, 0, 20'h0021F),
        mk(OP_WR , 8, 1, 20'hA6000),   // R8 read of reg 0x26
        mk(OP_STB, 8, 0, 20'h00000),
        mk(OP_SET, 8, 0, 20'h28000),
        mk(OP_SET, 8, 1, 20'h55550),
        mk(OP_STB, 8, 0, 20'h00003),
        mk(OP_RD , 8, 5, 20'h00014),   // R8 valid1 + mismatch, no valid2
        mk(OP_RD , 8, 4, 20'hBEEF0),   // R8 old slot2 word kept
        mk(OP_WR , 9, 0, 20'h0031F),
        mk(OP_STB, 9, 0, 20'h00000),
        mk(OP_CHK, 9, 3, 20'h00003),   // R9 codec 3
        mk(OP_WR , 10, 2, 20'h11110),
        mk(OP_STB, 10, 0, 20'h00003),
        mk(OP_RD , 10, 5, 20'h0001E),  // R10 setup: all flags but busy1
        mk(OP_WR , 10, 0, 20'h0031E),  // R10 global enable off
        mk(OP_NOP, 10, 0, 20'h00000),
        mk(OP_RD , 10, 5, 20'h00000),  // R10 flags cleared
        mk(OP_RD , 10, 3, 20'h00000),  // R10 rx1 cleared
        mk(OP_WR , 10, 1, 20'h03000),  // ignored
        mk(OP_WR , 10, 0, 20'h0031F),
        mk(OP_STB, 10, 0, 20'h00000),
        mk(OP_CHK, 10, 0, 20'h00000)   // R10 write while off ignored
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic          host_rd = 1'b0;
    logic [2:0]    host_addr = '0;
    logic [SW-1:0] host_wdata = '0;
    logic [SW-1:0] host_rdata;
    logic          frame_strobe = 1'b0;
    logic [1:0]    in_tag = '0;
    logic [SW-1:0] in_slot1 = '0;
    logic [SW-1:0] in_slot2 = '0;
    logic [1:0]    tx_tag;
    logic [SW-1:0] tx_slot1;
    logic [SW-1:0] tx_slot2;
    logic [1:0]    tx_codec;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    codec_cmd_engine u0 (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .frame_strobe(frame_strobe), .in_tag(in_tag),
        .in_slot1(in_slot1), .in_slot2(in_slot2),
        .tx_tag(tx_tag), .tx_slot1(tx_slot1), .tx_slot2(tx_slot2),
        .tx_codec(tx_codec)
    );

    task automatic check(input int rq, input string what,
                         input logic [SW-1:0] act, input logic [SW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // one op per cycle: drive at the falling edge, sample 1 ns later
    task automatic run_op(input logic [29:0] v);
        logic [2:0]  op;
        logic [3:0]  rq;
        logic [2:0]  a;
        logic [19:0] d;
        {op, rq, a, d} = v;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0; frame_strobe = 1'b0; in_tag = '0;
        case (op)
            OP_WR:  begin host_wr = 1'b1; host_addr = a; host_wdata = d; end
            OP_RD:  begin
                host_rd = 1'b1; host_addr = a;
                #1 check(int'(rq), "host read", host_rdata, d);
            end
            OP_STB: begin frame_strobe = 1'b1; in_tag = d[1:0]; end
            OP_SET: begin if (a == 3'd0) in_slot1 = d; else in_slot2 = d; end
            OP_CHK: begin
                #1;
                case (a)
                    3'd0:    check(int'(rq), "tx_tag",   {18'd0, tx_tag}, d);
                    3'd1:    check(int'(rq), "tx_slot1", tx_slot1, d);
                    3'd2:    check(int'(rq), "tx_slot2", tx_slot2, d);
                    default: check(int'(rq), "tx_codec", {18'd0, tx_codec}, d);
                endcase
            end
            default: ;
        endcase
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        host_rd = 1'b1; host_addr = 3'd5;
        #1 check(1, "status in reset", host_rdata, '0);
        check(1, "tx_tag in reset", {18'd0, tx_tag}, '0);
        check(1, "tx_slot1 in reset", tx_slot1, '0);
        host_addr = 3'd0;
        #1 check(1, "control in reset", host_rdata, '0);
        host_rd = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_op(VEC[i]);

        // R3 corner: a second slot-2 write after arming disarms it
        run_op(mk(OP_WR , 3, 2, 20'h22220));
        run_op(mk(OP_WR , 3, 1, 20'h04000));
        run_op(mk(OP_WR , 3, 2, 20'h33330));
        run_op(mk(OP_STB, 3, 0, 20'h00000));
        run_op(mk(OP_CHK, 3, 0, 20'h00001));
        run_op(mk(OP_RD , 3, 5, 20'h00002));

        // R1: reset in mid-activity clears pending state and outputs
        run_op(mk(OP_WR , 1, 1, 20'h05000));
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0; frame_strobe = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        host_rd = 1'b1; host_addr = 3'd5;
        #1 check(1, "status after reset", host_rdata, '0);
        check(1, "codec after reset", {18'd0, tx_codec}, '0);
        check(1, "tx_slot2 after reset", tx_slot2, '0);
        host_rd = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule